// File: doc/BRIEF.md
# Dual-Mode Serial Peripheral Port

This block is a byte-wide SPI port that works either as the bus master or as a selected slave. An 8-bit configuration/status word chooses the role, the clock polarity and the clock phase. The same word reports whether a transfer is running, the filtered and the raw state of the select pin, and two slave-side buffer flags. Software writes a byte into a single-entry transmit buffer and reads completed bytes from a single-entry receive buffer.

As master, the port makes SCK from the system clock. Each bit lasts 2×(clk_div+1) system clocks. The port shifts out eight bits, most significant first, and samples MISO on the last system clock of each bit. As slave, the port brings SCK, MOSI and the select pin into the clock domain. It samples MOSI on the sampling edge and drives MISO from its shift register. The select pin passes through a two-flop synchronizer and then a three-sample agreement filter.

Top module: `spi_duplex_port`

## Requirements
- R1: After reset, with the select pin high, the configuration/status word reads 8'h07.
- R2: A write to the word changes only bit 6 (1 = master, 0 = slave), bit 5 (phase) and bit 4 (polarity). Writes to bits 7, 3, 2, 1 and 0 have no effect.
- R3: In master mode, a byte waiting in the transmit buffer starts a transfer of 8 bits, sent MSB first on MOSI. Each bit lasts 2×(clk_div+1) clocks, so busy (bit 7) stays high for 16×(clk_div+1) clocks.
- R4: In master mode, SCK rests at the polarity bit while idle and makes 16 transitions per byte. The sampling edge is rising when polarity equals phase and falling otherwise. With phase 0 the sampling edge is the first transition of a bit; with phase 1 it is the second.
- R5: In master mode, MISO is captured on the last system clock of each bit. The received byte reaches rx_rdata when the transfer ends.
- R6: In slave mode, while selected, MOSI is captured on each sampling edge (same rule as R4). MISO presents the transmit byte MSB first and advances on the other edge. After 8 samples the byte goes to the receive buffer.
- R7: Bit 3 (selected) is 1 when the filtered select pin is low. It changes only after three consecutive equal synchronized samples, so a 2-clock low pulse leaves it at 0. Bit 2 follows the pin directly, with no register in the path.
- R8: In slave mode, SCK and MOSI activity while not selected has no effect on the received data, the receive flag or busy.
- R9: In slave mode, bit 1 (shift register empty) is 1 after reset. It goes to 0 when a transmit byte moves into the shift register. It returns to 1 at the end of a byte if no further transmit byte is waiting.
- R10: In slave mode, bit 0 (receive buffer empty) goes to 0 when a byte arrives. It goes to 1 after rx_re.
- R11: In master mode, bits 1 and 0 read as 1.
- R12: Busy reads 1 while a byte is in progress in either mode, and 0 after the byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration/status read value |
| tx_we | input | 1 | Write strobe into the transmit buffer |
| tx_wdata | input | DATA_W | Transmit byte |
| rx_re | input | 1 | Read strobe that empties the receive buffer |
| rx_rdata | output | DATA_W | Receive buffer contents |
| clk_div | input | DIV_W | Master half-bit length minus one, in clocks |
| sck_o | output | 1 | Master SCK drive |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Slave SCK in |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| nss_i | input | 1 | Slave select pin, active low |

## Verification
On every cycle, the assertions check four things: the selected flag moves only after three agreeing synchronized samples, master mode forces the two slave flags high, the master SCK rests at the polarity level when no transfer runs, and a master transfer never runs past its bit-time budget. They also check that a read of the receive buffer outside a byte empties it. Only the bench scenarios can show the data itself: the MSB-first order on both lines, the count and direction of SCK edges in all four modes, correct capture at the slave, rejection of activity while deselected, and the point at which a queued transmit byte is taken.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int unsigned BIT_BUSY   = 7;
  localparam int unsigned BIT_MASTER = 6;
  localparam int unsigned BIT_CPHA   = 5;
  localparam int unsigned BIT_CPOL   = 4;
  localparam int unsigned BIT_SEL    = 3;
  localparam int unsigned BIT_RAW    = 2;
  localparam int unsigned BIT_SRMT   = 1;
  localparam int unsigned BIT_RXBMT  = 0;

  typedef struct packed {
    logic master;
    logic cpha;
    logic cpol;
  } spi_mode_t;
endpackage

// File: rtl/spi_nss_filter.sv
module spi_nss_filter #(
  parameter int unsigned SYNC_N  = 2,
  parameter int unsigned AGREE_N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic synced_o,
  output logic filt_o
);
  logic [SYNC_N-1:0]  sync_q;
  logic [AGREE_N-2:0] hist_q;
  logic               filt_q;
  logic [AGREE_N-1:0] window;

  assign window = {hist_q, sync_q[SYNC_N-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin_i};
      hist_q <= window[AGREE_N-2:0];
      if (&window)       filt_q <= 1'b1;
      else if (~|window) filt_q <= 1'b0;
    end
  end

  assign synced_o = sync_q[SYNC_N-1];
  assign filt_o   = filt_q;
endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic mosi_i,
  output logic rise_o,
  output logic fall_o,
  output logic mosi_o
);
  logic [SYNC_N:0]   sck_q;
  logic [SYNC_N-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= '0;
      dat_q <= '0;
    end else begin
      sck_q <= {sck_q[SYNC_N-1:0], sck_i};
      dat_q <= {dat_q[SYNC_N-2:0], mosi_i};
    end
  end

  assign rise_o = sck_q[SYNC_N-1] & ~sck_q[SYNC_N];
  assign fall_o = ~sck_q[SYNC_N-1] & sck_q[SYNC_N];
  assign mosi_o = dat_q[SYNC_N-1];
endmodule

// File: rtl/spi_master_timer.sv
module spi_master_timer #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             active_o,
  output logic             half_o,
  output logic             bit_end_o,
  output logic             last_bit_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic             active_q, half_q;
  logic [DIV_W-1:0] tick_q;
  logic [CNT_W-1:0] bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      tick_q   <= '0;
      bit_q    <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        half_q   <= 1'b0;
        tick_q   <= '0;
        bit_q    <= '0;
      end
    end else if (tick_q == div_i) begin
      tick_q <= '0;
      half_q <= ~half_q;
      if (half_q) begin
        bit_q <= bit_q + 1'b1;
        if (bit_q == LAST) active_q <= 1'b0;
      end
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign active_o   = active_q;
  assign half_o     = half_q;
  assign bit_end_o  = active_q && half_q && (tick_q == div_i);
  assign last_bit_o = (bit_q == LAST);
endmodule

// File: rtl/spi_duplex_port.sv
module spi_duplex_port
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned SYNC_N  = 2,
  parameter int unsigned AGREE_N = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_re,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              nss_i
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  spi_mode_t         mode_q;
  logic [DATA_W-1:0] txbuf_q, rxbuf_q, sh_q, rsh_q;
  logic              tx_full_q, rx_full_q, srmt_q;
  logic [CNT_W-1:0]  scnt_q;

  logic nss_synced, nss_filt, slv_sel;
  logic s_rise, s_fall, mosi_s;
  logic m_active, m_half, m_bit_end, m_last;
  logic m_start, s_sample, s_shift, s_load, busy;
  logic [DATA_W-1:0] m_rx_next, s_rx_next;

  spi_nss_filter #(.SYNC_N(SYNC_N), .AGREE_N(AGREE_N)) u_nss (
    .clk(clk), .rst(rst), .pin_i(nss_i), .synced_o(nss_synced), .filt_o(nss_filt)
  );

  spi_slave_sync #(.SYNC_N(SYNC_N)) u_ssync (
    .clk(clk), .rst(rst), .sck_i(sck_i), .mosi_i(mosi_i),
    .rise_o(s_rise), .fall_o(s_fall), .mosi_o(mosi_s)
  );

  spi_master_timer #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_mtim (
    .clk(clk), .rst(rst), .start_i(m_start), .div_i(clk_div),
    .active_o(m_active), .half_o(m_half), .bit_end_o(m_bit_end), .last_bit_o(m_last)
  );

  assign slv_sel   = ~nss_filt;
  assign m_start   = mode_q.master && tx_full_q && !m_active;
  assign s_sample  = !mode_q.master && slv_sel &&
                     ((mode_q.cpol == mode_q.cpha) ? s_rise : s_fall);
  assign s_shift   = !mode_q.master && slv_sel &&
                     ((mode_q.cpol == mode_q.cpha) ? s_fall : s_rise);
  assign s_load    = !mode_q.master && srmt_q && tx_full_q &&
                     (scnt_q == '0) && !s_sample;
  assign m_rx_next = {rsh_q[DATA_W-2:0], miso_i};
  assign s_rx_next = {rsh_q[DATA_W-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      txbuf_q   <= '0;
      rxbuf_q   <= '0;
      sh_q      <= '0;
      rsh_q     <= '0;
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
      srmt_q    <= 1'b1;
      scnt_q    <= '0;
    end else begin
      if (cfg_we) begin
        mode_q.master <= cfg_wdata[BIT_MASTER];
        mode_q.cpha   <= cfg_wdata[BIT_CPHA];
        mode_q.cpol   <= cfg_wdata[BIT_CPOL];
      end
      if (rx_re) rx_full_q <= 1'b0;

      // master path
      if (m_start) begin
        sh_q      <= txbuf_q;
        tx_full_q <= 1'b0;
      end
      if (m_bit_end) begin
        rsh_q <= m_rx_next;
        sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
        if (m_last) begin
          rxbuf_q   <= m_rx_next;
          rx_full_q <= 1'b1;
        end
      end

      // slave path
      if (!slv_sel || mode_q.master) scnt_q <= '0;
      if (s_sample) begin
        rsh_q <= s_rx_next;
        if (scnt_q == LAST) begin
          scnt_q    <= '0;
          rxbuf_q   <= s_rx_next;
          rx_full_q <= 1'b1;
          if (tx_full_q) begin
            sh_q      <= txbuf_q;
            tx_full_q <= 1'b0;
          end else begin
            srmt_q <= 1'b1;
          end
        end else begin
          scnt_q <= scnt_q + 1'b1;
          if (scnt_q == '0) srmt_q <= 1'b0;
        end
      end else if (s_shift && (scnt_q != '0)) begin
        sh_q <= {sh_q[DATA_W-2:0], 1'b0};
      end
      if (s_load) begin
        sh_q      <= txbuf_q;
        tx_full_q <= 1'b0;
        srmt_q    <= 1'b0;
      end

      if (tx_we && !tx_full_q) begin
        txbuf_q   <= tx_wdata;
        tx_full_q <= 1'b1;
      end
    end
  end

  assign busy     = mode_q.master ? m_active : (slv_sel && (scnt_q != '0));
  assign sck_o    = (mode_q.master && m_active) ? (mode_q.cpol ^ mode_q.cpha ^ m_half)
                                                : mode_q.cpol;
  assign mosi_o   = mode_q.master & sh_q[DATA_W-1];
  assign miso_o   = ~mode_q.master & sh_q[DATA_W-1];
  assign rx_rdata = rxbuf_q;

  always_comb begin
    cfg_rdata             = '0;
    cfg_rdata[BIT_BUSY]   = busy;
    cfg_rdata[BIT_MASTER] = mode_q.master;
    cfg_rdata[BIT_CPHA]   = mode_q.cpha;
    cfg_rdata[BIT_CPOL]   = mode_q.cpol;
    cfg_rdata[BIT_SEL]    = slv_sel;
    cfg_rdata[BIT_RAW]    = nss_i;
    cfg_rdata[BIT_SRMT]   = mode_q.master | srmt_q;
    cfg_rdata[BIT_RXBMT]  = mode_q.master | ~rx_full_q;
  end
endmodule

// File: rtl/spi_duplex_port_chk.sv
module spi_duplex_port_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       stat,
  input logic             sck_o,
  input logic             rx_re,
  input logic             nss_synced,
  input logic [DIV_W-1:0] clk_div
);
  logic master_en, busy, cpol, slv_sel, srmt, rxbmt;
  assign busy      = stat[7];
  assign master_en = stat[6];
  assign cpol      = stat[4];
  assign slv_sel   = stat[3];
  assign srmt      = stat[1];
  assign rxbmt     = stat[0];

  logic [31:0] run_q;
  logic [31:0] limit;
  assign limit = 32'(2 * DATA_W) * (32'(clk_div) + 32'd1);

  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (busy) run_q <= run_q + 32'd1;
    else           run_q <= '0;
  end

  AST_SEL_AFTER_THREE: assert property (@(posedge clk) disable iff (rst)
    !$stable(slv_sel) |-> ($past(nss_synced, 1) == $past(nss_synced, 2)) &&
                          ($past(nss_synced, 2) == $past(nss_synced, 3)) &&
                          (slv_sel == !$past(nss_synced, 1))); // R7

  AST_MASTER_FLAGS_HIGH: assert property (@(posedge clk) disable iff (rst)
    master_en |-> (srmt && rxbmt)); // R11

  AST_IDLE_SCK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (master_en && !busy) |-> (sck_o == cpol)); // R4

  AST_RX_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (!master_en && rx_re && !busy) |=> rxbmt); // R10

  AST_BUSY_WITHIN_BUDGET: assert property (@(posedge clk) disable iff (rst)
    (master_en && busy) |-> (run_q < limit)); // R3
endmodule

bind spi_duplex_port spi_duplex_port_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .stat(cfg_rdata), .sck_o(sck_o), .rx_re(rx_re),
  .nss_synced(nss_synced), .clk_div(clk_div)
);

// File: tb/tb_spi_duplex_port.sv
module tb_spi_duplex_port;
  localparam int H = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       tx_we = 1'b0;
  logic [7:0] tx_wdata = '0;
  logic       rx_re = 1'b0;
  logic [7:0] rx_rdata;
  logic [7:0] clk_div = '0;
  logic       sck_o, mosi_o, miso_i, miso_o;
  logic       sck_i = 1'b0, mosi_i = 1'b0, nss_i = 1'b1;
  logic       inv_q = 1'b0;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  assign miso_i = mosi_o ^ inv_q;

  spi_duplex_port dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_re(rx_re), .rx_rdata(rx_rdata),
    .clk_div(clk_div), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .sck_i(sck_i), .mosi_i(mosi_i), .miso_o(miso_o), .nss_i(nss_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic mxfer(input logic [7:0] tx, input logic cp, input logic ph,
                       input logic [7:0] d, input logic inv);
    int busy_n = 0;
    int edges  = 0;
    logic [7:0] seen = '0;
    logic prev;
    bit started = 0;
    clk_div = d; inv_q = inv;
    cfg_write({1'b0, 1'b1, ph, cp, 4'b0});
    prev = sck_o;
    tx_we = 1'b1; tx_wdata = tx;
    @(negedge clk); tx_we = 1'b0;
    for (int g = 0; g < 2000; g++) begin
      if (cfg_rdata[7]) begin busy_n++; started = 1; end
      if (sck_o != prev) begin
        edges++;
        if (sck_o == (cp == ph)) seen = {seen[6:0], mosi_o};
        prev = sck_o;
      end
      if (started && !cfg_rdata[7]) break;
      @(negedge clk);
    end
    chk(busy_n == 16 * (int'(d) + 1), "R3 busy length", busy_n, 16 * (int'(d) + 1));
    chk(seen == tx, "R3 MOSI MSB-first at sampling edges", seen, tx);
    chk(edges == 16, "R4 SCK edge count", edges, 16);
    chk(sck_o == cp, "R4 SCK idle level", sck_o, cp);
    chk(rx_rdata == (tx ^ {8{inv}}), "R5 master received byte", rx_rdata, tx ^ {8{inv}});
    chk(cfg_rdata[1:0] == 2'b11, "R11 slave flags forced in master", cfg_rdata[1:0], 3);
  endtask

  task automatic sxfer(input logic [7:0] tx, input logic [7:0] rxb,
                       input logic cp, input logic ph);
    logic [7:0] got = '0;
    cfg_write({1'b0, 1'b0, ph, cp, 4'b0});
    sck_i = cp; mosi_i = 1'b0;
    tx_we = 1'b1; tx_wdata = tx;
    @(negedge clk); tx_we = 1'b0;
    @(negedge clk);
    chk(cfg_rdata[1] == 1'b0, "R9 shift register loaded", cfg_rdata[1], 0);
    nss_i = 1'b0;
    #1 chk(cfg_rdata[2] == 1'b0, "R7 raw select bit follows pin", cfg_rdata[2], 0);
    repeat (8) @(negedge clk);
    chk(cfg_rdata[3] == 1'b1, "R7 selected after filter", cfg_rdata[3], 1);
    for (int i = 7; i >= 0; i--) begin
      if (!ph) begin
        mosi_i = rxb[i];
        repeat (H) @(negedge clk);
        sck_i = ~cp; got[i] = miso_o;
        repeat (H) @(negedge clk);
        sck_i = cp;
      end else begin
        sck_i = ~cp; mosi_i = rxb[i];
        repeat (H) @(negedge clk);
        sck_i = cp; got[i] = miso_o;
        repeat (H) @(negedge clk);
      end
      if (i == 4) chk(cfg_rdata[7] == 1'b1, "R12 busy mid-byte (slave)", cfg_rdata[7], 1);
    end
    repeat (6) @(negedge clk);
    chk(rx_rdata == rxb, "R6 slave received byte", rx_rdata, rxb);
    chk(got == tx, "R6 slave MISO MSB-first", got, tx);
    chk(cfg_rdata[0] == 1'b0, "R10 receive buffer full", cfg_rdata[0], 0);
    chk(cfg_rdata[1] == 1'b1, "R9 shift register empty at byte end", cfg_rdata[1], 1);
    chk(cfg_rdata[7] == 1'b0, "R12 busy cleared after byte", cfg_rdata[7], 0);
    rx_re = 1'b1;
    @(negedge clk); rx_re = 1'b0;
    chk(cfg_rdata[0] == 1'b1, "R10 empty after read", cfg_rdata[0], 1);
    nss_i = 1'b1;
    repeat (8) @(negedge clk);
    chk(cfg_rdata[3] == 1'b0, "R7 deselected after filter", cfg_rdata[3], 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] keep;
    bit saw_sel;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_rdata == 8'h07, "R1 reset value", cfg_rdata, 8'h07);

    cfg_write(8'hFF);
    chk(cfg_rdata == 8'h77, "R2 only mode bits writable", cfg_rdata, 8'h77);
    cfg_write(8'h08);
    chk(cfg_rdata == 8'h07, "R2 read-only bits ignore write", cfg_rdata, 8'h07);

    // R7: a two-clock glitch must not select
    saw_sel = 0;
    nss_i = 1'b0;
    repeat (2) @(negedge clk);
    nss_i = 1'b1;
    for (int k = 0; k < 10; k++) begin
      if (cfg_rdata[3]) saw_sel = 1;
      @(negedge clk);
    end
    chk(!saw_sel, "R7 glitch rejected", saw_sel, 0);

    // R8: activity while deselected
    keep = rx_rdata;
    for (int k = 0; k < 16; k++) begin
      sck_i = ~sck_i; mosi_i = k[1];
      repeat (H) @(negedge clk);
    end
    sck_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(cfg_rdata[0] == 1'b1, "R8 no byte received while deselected", cfg_rdata[0], 1);
    chk(cfg_rdata[7] == 1'b0, "R8 not busy while deselected", cfg_rdata[7], 0);
    chk(rx_rdata == keep, "R8 receive data unchanged", rx_rdata, keep);

    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 32; b++) begin
        sxfer(8'((b * 53 + m * 17 + 1) & 8'hFF), 8'((b * 29 + m * 71 + 0) ^ 8'hA5),
              m[1], m[0]);
      end
    end

    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 256; b++) begin
        mxfer(8'(b), m[1], m[0], 8'(b % 4), b[0] ^ m[1]);
      end
    end

    finish_run();
  end
endmodule